// File: doc/BRIEF.md
# Serial Link FIFO Status and Service-Request Unit

This block sits beside the transmit and receive FIFOs of a synchronous bit-oriented serial link controller. It watches the FIFO fill levels, the tag bits of the oldest receive entries, a transmit-fetch strobe and the received bit stream. From these it keeps an 8-bit status word on a simple register bus. That word holds two kinds of flag. Sticky error flags are cleared by writing a one to them. Live service-request flags follow the FIFO levels from cycle to cycle.

From the same flags the block drives one DMA request per direction and a single interrupt line. Enable and mask bits gate both. A receive entry whose tags mark an error blocks receive DMA, so software handles the error before any more data is moved. A run-of-ones detector spots an aborted frame. It sets a sticky flag and pulses a marker, which the receive path uses to tag the last good entry as end of frame.

The sticky flags have no defined reset value. Software clears them by writing ones before it enables the link. The reset input is asserted low and acts asynchronously. Its release is synchronized to the clock inside the block, so internal state leaves reset two clock edges after `rst_n` rises.

Top module: `slk_stat_unit`

## Requirements
- R1: The status word read on `reg_rdata` has error-in-FIFO at bit 0, transmit underrun at bit 1, receive abort at bit 2, transmit service at bit 3 and receive service at bit 4. Bits 7..5 always read zero. Writes have no effect on bits 0, 3, 4 and 7..5.
- R2: A register write with a one at bit 1 or bit 2 clears that sticky flag after the write edge. A write with a zero there leaves the flag unchanged.
- R3: If a hardware set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: Error-in-FIFO is high while any of the three tag bits is set in any of the four oldest receive entries. Entry k is tag bits [3k+2:3k] of `rx_old_tags`. An entry counts only if its index is below `rx_level`.
- R5: While error-in-FIFO is high, `rx_dma_req` is low.
- R6: The underrun flag sets on the edge where `tx_fetch` is high and `tx_level` is zero. A fetch from a non-empty FIFO does not set it.
- R7: With `rx_en` and `rx_in_frame` high, the seventh consecutive valid one sets the abort flag. On the same edge it raises `eof_mark` for exactly one cycle. A valid zero restarts the count. Ones are not counted while `rx_en` or `rx_in_frame` is low.
- R8: Transmit service and `tx_dma_req` are high exactly when `tx_en` is high and `tx_level` is 4 or less.
- R9: Receive service is high exactly when `rx_en` is high and `rx_level` is 5 or more. `rx_dma_req` equals receive service with error-in-FIFO low.
- R10: One edge after the condition arises, `irq` equals the OR of five terms: error-in-FIFO, underrun AND `tur_ie`, abort AND `rab_ie`, transmit service AND `tx_ie`, and receive service AND `rx_ie`.
- R11: While reset is asserted, `irq` and `eof_mark` are low. The abort run count is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 8 | Write data; ones clear sticky flags |
| reg_rdata | output | 8 | Status word |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_ie | input | 1 | Transmit service interrupt enable |
| rx_ie | input | 1 | Receive service interrupt enable |
| tur_ie | input | 1 | Underrun interrupt mask (1 = permitted) |
| rab_ie | input | 1 | Abort interrupt enable |
| tx_level | input | 4 | Transmit FIFO fill count (0..8) |
| rx_level | input | 4 | Receive FIFO fill count (0..12) |
| rx_old_tags | input | 12 | Tag bits of the four oldest receive entries |
| tx_fetch | input | 1 | Transmit logic fetch strobe |
| rx_bit | input | 1 | Received bit value |
| rx_bit_vld | input | 1 | Received bit strobe |
| rx_in_frame | input | 1 | Receiver is inside a frame |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Registered interrupt request |
| eof_mark | output | 1 | One-cycle pulse to tag the last good entry as end of frame |

## Verification
Suppose a sticky flag fails to hold, or holds against a clearing write. The status word shows it on the very next read. If the interrupt mask allows it, `irq` shows it one edge later. Suppose the run counter is off by one. Then the abort flag and `eof_mark` appear one received bit early or late, or not at all after a zero breaks the run, so the fault shows at the port on the bit where it goes wrong. A fault in the tag window or a level threshold shows at once on the combinational DMA requests, because those follow the inputs with no register.

// File: rtl/slk_stat_pkg.sv
package slk_stat_pkg;
  localparam int REG_W = 8;
  localparam int B_EIF = 0;
  localparam int B_TUR = 1;
  localparam int B_RAB = 2;
  localparam int B_TFS = 3;
  localparam int B_RFS = 4;
  localparam int N_FLAG = 5;

  typedef struct packed {
    logic rfs;
    logic tfs;
    logic rab;
    logic tur;
    logic eif;
  } stat_t;
endpackage

// File: rtl/slk_rst_sync.sv
module slk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/slk_tag_scan.sv
module slk_tag_scan #(
  parameter int ERR_WIN = 4,
  parameter int TAG_W   = 3,
  parameter int LVL_W   = 4
) (
  input  logic [LVL_W-1:0]         rx_level,
  input  logic [ERR_WIN*TAG_W-1:0] rx_tags,
  output logic                     err_any
);
  logic [ERR_WIN-1:0] ent_hit;

  for (genvar i = 0; i < ERR_WIN; i++) begin : g_ent
    assign ent_hit[i] = (int'(rx_level) > i) && (|rx_tags[i*TAG_W +: TAG_W]);
  end

  assign err_any = |ent_hit;
endmodule

// File: rtl/slk_run_det.sv
module slk_run_det #(
  parameter int RUN_LEN = 7,
  parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic active,
  input  logic bit_vld,
  input  logic bit_val,
  output logic run_hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (!active) begin
      cnt_d = '0;
    end else if (bit_vld) begin
      if (!bit_val) begin
        cnt_d = '0;
      end else if (cnt_q != CNT_W'(RUN_LEN)) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_en  = !active || bit_vld;
  assign run_hit = active && bit_vld && bit_val && (cnt_q == CNT_W'(RUN_LEN - 1));

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/slk_stat_regs.sv
module slk_stat_regs
  import slk_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             tur_set,
  input  logic             rab_set,
  input  logic             eif,
  input  logic             tfs,
  input  logic             rfs,
  input  logic             tx_ie,
  input  logic             rx_ie,
  input  logic             tur_ie,
  input  logic             rab_ie,
  output stat_t            stat,
  output logic             irq_q,
  output logic             eof_q
);
  logic [REG_W-1:0] clr_vec;
  logic tur_q, tur_d, tur_en;
  logic rab_q, rab_d, rab_en;
  logic irq_d;

  assign clr_vec = wr ? wdata : '0;

  always_comb begin
    tur_en = tur_set || clr_vec[B_TUR];
    rab_en = rab_set || clr_vec[B_RAB];
    tur_d  = (tur_q && !clr_vec[B_TUR]) || tur_set;
    rab_d  = (rab_q && !clr_vec[B_RAB]) || rab_set;
    irq_d  = eif || (tur_q && tur_ie) || (rab_q && rab_ie) ||
             (tfs && tx_ie) || (rfs && rx_ie);
  end

  always_ff @(posedge clk) begin
    if (tur_en) begin
      tur_q <= tur_d;
    end
    if (rab_en) begin
      rab_q <= rab_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      eof_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      eof_q <= rab_set;
    end
  end

  always_comb begin
    stat.eif = eif;
    stat.tur = tur_q;
    stat.rab = rab_q;
    stat.tfs = tfs;
    stat.rfs = rfs;
  end
endmodule

// File: rtl/slk_stat_unit.sv
module slk_stat_unit
  import slk_stat_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 12,
  parameter int TX_THR   = 4,
  parameter int RX_THR   = 5,
  parameter int ERR_WIN  = 4,
  parameter int TAG_W    = 3,
  parameter int RUN_LEN  = 7,
  parameter int TX_LW    = $clog2(TX_DEPTH + 1),
  parameter int RX_LW    = $clog2(RX_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  input  logic                     tx_en,
  input  logic                     rx_en,
  input  logic                     tx_ie,
  input  logic                     rx_ie,
  input  logic                     tur_ie,
  input  logic                     rab_ie,
  input  logic [TX_LW-1:0]         tx_level,
  input  logic [RX_LW-1:0]         rx_level,
  input  logic [ERR_WIN*TAG_W-1:0] rx_old_tags,
  input  logic                     tx_fetch,
  input  logic                     rx_bit,
  input  logic                     rx_bit_vld,
  input  logic                     rx_in_frame,
  output logic                     tx_dma_req,
  output logic                     rx_dma_req,
  output logic                     irq,
  output logic                     eof_mark
);
  localparam int PAD_W = REG_W - N_FLAG;

  logic  rst_sync_n;
  logic  eif, tfs, rfs;
  logic  tur_set, rab_set;
  stat_t stat;

  slk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  slk_tag_scan #(
    .ERR_WIN (ERR_WIN),
    .TAG_W   (TAG_W),
    .LVL_W   (RX_LW)
  ) u_scan (
    .rx_level (rx_level),
    .rx_tags  (rx_old_tags),
    .err_any  (eif)
  );

  slk_run_det #(
    .RUN_LEN (RUN_LEN)
  ) u_run (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .active  (rx_en && rx_in_frame),
    .bit_vld (rx_bit_vld),
    .bit_val (rx_bit),
    .run_hit (rab_set)
  );

  assign tfs     = tx_en && (tx_level <= TX_LW'(TX_THR));
  assign rfs     = rx_en && (rx_level >= RX_LW'(RX_THR));
  assign tur_set = tx_fetch && (tx_level == '0);

  slk_stat_regs u_regs (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .tur_set (tur_set),
    .rab_set (rab_set),
    .eif     (eif),
    .tfs     (tfs),
    .rfs     (rfs),
    .tx_ie   (tx_ie),
    .rx_ie   (rx_ie),
    .tur_ie  (tur_ie),
    .rab_ie  (rab_ie),
    .stat    (stat),
    .irq_q   (irq),
    .eof_q   (eof_mark)
  );

  assign reg_rdata  = {{PAD_W{1'b0}}, stat};
  assign tx_dma_req = stat.tfs;
  assign rx_dma_req = stat.rfs && !stat.eif;
endmodule

// File: rtl/slk_stat_chk.sv
module slk_stat_chk #(
  parameter int TX_LW = 4
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             tx_en,
  input logic             tur_ie,
  input logic [TX_LW-1:0] tx_level,
  input logic             tx_fetch,
  input logic             tx_dma_req,
  input logic             rx_dma_req,
  input logic             irq,
  input logic             eof_mark
);
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_rdata[7:5] == 3'b000);

  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && reg_wdata[1] && !(tx_fetch && tx_level == '0)) |=> !reg_rdata[1]);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && reg_wdata[1] && tx_fetch && tx_level == '0) |=> reg_rdata[1]);

  p_eif_block_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_rdata[0] |-> !rx_dma_req);

  p_tur_set_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_fetch && tx_level == '0) |=> reg_rdata[1]);

  p_abort_mark_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    eof_mark |-> reg_rdata[2]);

  p_eof_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    eof_mark |=> !eof_mark);

  p_tfs_off_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !tx_en |-> (!tx_dma_req && !reg_rdata[3]));

  p_irq_tur_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_rdata[1] && tur_ie) |=> irq);

  p_irq_eif_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_rdata[0] |=> irq);
endmodule

bind slk_stat_unit slk_stat_chk #(.TX_LW(TX_LW)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .tx_en      (tx_en),
  .tur_ie     (tur_ie),
  .tx_level   (tx_level),
  .tx_fetch   (tx_fetch),
  .tx_dma_req (tx_dma_req),
  .rx_dma_req (rx_dma_req),
  .irq        (irq),
  .eof_mark   (eof_mark)
);

// File: tb/slk_stat_unit_tb_top.sv
module slk_stat_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        tx_en, rx_en, tx_ie, rx_ie, tur_ie, rab_ie;
  logic [3:0]  tx_level;
  logic [3:0]  rx_level;
  logic [11:0] rx_old_tags;
  logic        tx_fetch, rx_bit, rx_bit_vld, rx_in_frame;
  logic        tx_dma_req, rx_dma_req, irq, eof_mark;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  slk_stat_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .tx_ie       (tx_ie),
    .rx_ie       (rx_ie),
    .tur_ie      (tur_ie),
    .rab_ie      (rab_ie),
    .tx_level    (tx_level),
    .rx_level    (rx_level),
    .rx_old_tags (rx_old_tags),
    .tx_fetch    (tx_fetch),
    .rx_bit      (rx_bit),
    .rx_bit_vld  (rx_bit_vld),
    .rx_in_frame (rx_in_frame),
    .tx_dma_req  (tx_dma_req),
    .rx_dma_req  (rx_dma_req),
    .irq         (irq),
    .eof_mark    (eof_mark)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic quiet_all();
    reg_wr = 0; reg_wdata = '0; tx_fetch = 0; rx_bit_vld = 0; rx_bit = 0;
    tx_en = 0; rx_en = 0; tx_ie = 0; rx_ie = 0; tur_ie = 0; rab_ie = 0;
    tx_level = 4'd8; rx_level = 4'd0; rx_old_tags = '0; rx_in_frame = 0;
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic send_bits(input int n, input logic b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_bit_vld = 1; rx_bit = b;
    end
  endtask

  task automatic end_bits();
    @(negedge clk); rx_bit_vld = 0; rx_bit = 0;
  endtask

  task automatic t_reset();
    quiet_all();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R11 irq in reset", irq, 0);
    chk("R11 eof_mark in reset", eof_mark, 0);
    chk("R1 reserved in reset", reg_rdata[7:5], 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    wr_reg(8'hFF);
    chk("R2 sticky cleared", reg_rdata[2:1], 0);
  endtask

  task automatic t_layout();
    @(negedge clk); tx_en = 1; tx_level = 4'd2;
    #1 chk("R1 tfs at bit3", reg_rdata, 8'h08);
    wr_reg(8'hFF);
    chk("R1 write ignored on ro/reserved", reg_rdata, 8'h08);
    @(negedge clk); tx_en = 0; tx_level = 4'd8;
  endtask

  task automatic t_underrun();
    @(negedge clk); tx_level = 4'd3; tx_fetch = 1;
    @(negedge clk); tx_fetch = 0;
    chk("R6 fetch non-empty no set", reg_rdata[1], 0);
    tx_level = 4'd0; tx_fetch = 1;
    @(negedge clk); tx_fetch = 0;
    chk("R6 fetch empty sets", reg_rdata[1], 1);
    wr_reg(8'h00);
    chk("R2 zero write keeps", reg_rdata[1], 1);
    wr_reg(8'h02);
    chk("R2 one write clears", reg_rdata[1], 0);
    @(negedge clk); tx_fetch = 1; reg_wr = 1; reg_wdata = 8'h02;
    @(negedge clk); tx_fetch = 0; reg_wr = 0; reg_wdata = '0;
    chk("R3 set wins", reg_rdata[1], 1);
    wr_reg(8'h02);
    tx_level = 4'd8;
  endtask

  task automatic t_irq();
    @(negedge clk); tx_level = 4'd0; tx_fetch = 1;
    @(negedge clk); tx_fetch = 0; tx_level = 4'd8;
    @(negedge clk);
    chk("R10 masked underrun no irq", irq, 0);
    tur_ie = 1;
    #1 chk("R10 irq latency", irq, 0);
    @(negedge clk);
    chk("R10 underrun irq", irq, 1);
    tur_ie = 0;
    wr_reg(8'h02);
    @(negedge clk);
    chk("R10 irq drops", irq, 0);
    tx_en = 1; tx_level = 4'd4; tx_ie = 1;
    @(negedge clk);
    chk("R10 tx service irq", irq, 1);
    tx_level = 4'd6;
    @(negedge clk);
    chk("R10 tx above threshold no irq", irq, 0);
    tx_en = 0; tx_ie = 0; tx_level = 4'd8;
  endtask

  task automatic t_tx_svc();
    @(negedge clk); tx_en = 1; tx_level = 4'd4;
    #1 chk("R8 level 4", tx_dma_req, 1);
    tx_level = 4'd5;
    #1 chk("R8 level 5", tx_dma_req, 0);
    tx_level = 4'd0;
    #1 chk("R8 level 0", {tx_dma_req, reg_rdata[3]}, 2'b11);
    tx_en = 0;
    #1 chk("R8 disabled", {tx_dma_req, reg_rdata[3]}, 2'b00);
    tx_level = 4'd8;
  endtask

  task automatic t_rx_svc();
    @(negedge clk); rx_en = 1; rx_level = 4'd4;
    #1 chk("R9 level 4", {rx_dma_req, reg_rdata[4]}, 2'b00);
    rx_level = 4'd5;
    #1 chk("R9 level 5", {rx_dma_req, reg_rdata[4]}, 2'b11);
    rx_level = 4'd12;
    #1 chk("R9 level 12", rx_dma_req, 1);
    rx_en = 0;
    #1 chk("R9 disabled", {rx_dma_req, reg_rdata[4]}, 2'b00);
    rx_level = 4'd0;
  endtask

  task automatic t_err_tags();
    @(negedge clk); rx_en = 1; rx_level = 4'd6; rx_old_tags = 12'h080;
    #1 chk("R4 tag in entry2", reg_rdata[0], 1);
    chk("R5 dma blocked", {rx_dma_req, reg_rdata[4]}, 2'b01);
    @(negedge clk);
    chk("R10 eif irq unmasked", irq, 1);
    rx_level = 4'd2;
    #1 chk("R4 entry beyond level ignored", reg_rdata[0], 0);
    rx_level = 4'd4; rx_old_tags = 12'h800;
    #1 chk("R4 tag in entry3", reg_rdata[0], 1);
    rx_level = 4'd3;
    #1 chk("R4 entry3 beyond level", reg_rdata[0], 0);
    rx_level = 4'd6; rx_old_tags = '0;
    #1 chk("R5 dma resumes", rx_dma_req, 1);
    rx_en = 0; rx_level = 4'd0;
  endtask

  task automatic t_abort();
    @(negedge clk); rx_en = 1; rx_in_frame = 1;
    send_bits(6, 1); send_bits(1, 0); send_bits(6, 1);
    end_bits();
    chk("R7 broken run no abort", {reg_rdata[2], eof_mark}, 2'b00);
    send_bits(1, 1);
    end_bits();
    chk("R7 seventh one abort+eof", {reg_rdata[2], eof_mark}, 2'b11);
    @(negedge clk);
    chk("R7 eof one cycle", eof_mark, 0);
    send_bits(1, 1);
    end_bits();
    chk("R7 saturated no new eof", {reg_rdata[2], eof_mark}, 2'b10);
    rab_ie = 1;
    @(negedge clk);
    chk("R10 abort irq", irq, 1);
    rab_ie = 0;
    wr_reg(8'h04);
    chk("R2 abort cleared", reg_rdata[2], 0);
    rx_in_frame = 0;
    send_bits(8, 1);
    end_bits();
    chk("R7 outside frame ignored", {reg_rdata[2], eof_mark}, 2'b00);
    rx_in_frame = 1; rx_en = 0;
    send_bits(8, 1);
    end_bits();
    chk("R7 receiver off ignored", {reg_rdata[2], eof_mark}, 2'b00);
    rx_in_frame = 0;
  endtask

  initial begin
    t_reset();
    t_layout();
    t_underrun();
    t_irq();
    t_tx_svc();
    t_rx_svc();
    t_err_tags();
    t_abort();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule